// File: doc/BRIEF.md
# Prescaled 64-bit Timer with Self-Rearming Comparator

This block is a free-running 64-bit up-counter with a 64-bit comparator and one interrupt request line. Software reaches it through a plain register bus: a 32-bit byte address, a write strobe with 32-bit write data, and a read strobe with 32-bit read data. The counter steps once every (divider + 1) clock cycles while it is running. When the count is at or past the comparator, a raw event flag is latched.

In auto-rearm mode, every match adds a 32-bit step to the comparator, so the block can produce a periodic event without any software involvement. The raw flag is kept apart from the interrupt line. The line is only the raw flag qualified by an interrupt-enable bit, so software can poll events without taking interrupts.

The register port carries no stream data and has no back-pressure. A write completes in the cycle its strobe is high. Read data is combinational from the address while the read strobe is high.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and `irq` is low.
- R2: While control bit 0 (run) is set, the counter increments exactly once every (D + 1) clock cycles, where D is control bits 15:8. While run is clear, the count holds and the divider phase returns to zero.
- R3: The counter's low half is written at offset 0x00 and its high half at 0x04, and each reads back at the same offset. A write takes effect at the next edge and overrides an increment due in that cycle.
- R4: The control register sits at offset 0x08, with run at bit 0, compare-enable at bit 1, interrupt-enable at bit 2, auto-rearm at bit 3 and the divider in bits 15:8. Bits 7:4 and 31:16 always read zero, whatever was written to them.
- R5: While compare-enable is set and count ≥ comparator, the raw flag is set at the next edge. While compare-enable is clear, the raw flag is never set.
- R6: `irq` equals interrupt-enable AND the raw flag. The raw flag is set regardless of interrupt-enable.
- R7: Bit 0 of offset 0x0C reads the raw flag. Writing 1 to it clears the flag, and writing 0 leaves it unchanged. A match in the same cycle wins over the clear.
- R8: The comparator's low half is at 0x10, its high half at 0x14, and the step is at 0x18. In every cycle with a match while auto-rearm is set, the zero-extended step is added to the full 64-bit comparator, with carry into the high half. A comparator write in that cycle takes precedence over the addition.
- R9: A read at any offset other than the seven listed above, including misaligned ones, returns zero. `rd_data` is zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 32 | Byte offset for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request, level |

## Verification
Several rules are checked by the assertions on every cycle:
- the divider's tick spacing;
- the count and comparator holding when nothing may change them;
- a match always latching the raw flag;
- a write-one clear taking effect when there is no match;
- the exact step added on each auto-rearm;
- the reserved control bits and undecoded offsets reading zero.

Other behaviour only the bench scenarios can show: the exact count reached after a given number of divided ticks, carry of the comparator into its high half, a write-zero to status having no effect, and the interrupt following the enable bit. A behavioural model in the bench compares `irq` and `rd_data` against the design on every clock, including a long periodic run with auto-rearm.

// File: rtl/ct_pkg.sv
package ct_pkg;
  parameter int BUS_W   = 32;
  parameter int DIV_W   = 8;
  localparam int CNT_W  = 2 * BUS_W;

  localparam logic [BUS_W-1:0] OFS_CNT_LO = 32'h00;
  localparam logic [BUS_W-1:0] OFS_CNT_HI = 32'h04;
  localparam logic [BUS_W-1:0] OFS_CTRL   = 32'h08;
  localparam logic [BUS_W-1:0] OFS_STAT   = 32'h0C;
  localparam logic [BUS_W-1:0] OFS_CMP_LO = 32'h10;
  localparam logic [BUS_W-1:0] OFS_CMP_HI = 32'h14;
  localparam logic [BUS_W-1:0] OFS_STEP   = 32'h18;

  // Control word, LSB last: run is bit 0, divider occupies 15:8.
  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [3:0]       rsvd;
    logic             rearm;
    logic             irq_en;
    logic             cmp_en;
    logic             run;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] phase_q;

  assign tick = run && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (rst)        phase_q <= '0;
    else if (!run)  phase_q <= '0;
    else if (tick)  phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  // After a tick, another follows at once only for a divider of zero.
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || div == '0));
endmodule

// File: rtl/ct_compare.sv
module ct_compare #(
  parameter int CW = 64,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_en,
  input  logic          rearm,
  input  logic [CW-1:0] count,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [CW/2-1:0] wdata,
  input  logic [SW-1:0] step,
  input  logic          clr,
  output logic [CW-1:0] cmp,
  output logic          raw
);
  localparam int HW = CW / 2;

  logic [CW-1:0] cmp_q;
  logic          raw_q;
  logic          match;

  assign match = cmp_en && (count >= cmp_q);

  always_ff @(posedge clk) begin
    if (rst)                   cmp_q <= '0;
    else if (wr_lo)            cmp_q[HW-1:0]  <= wdata;
    else if (wr_hi)            cmp_q[CW-1:HW] <= wdata;
    else if (match && rearm)   cmp_q <= cmp_q + CW'(step);
  end

  always_ff @(posedge clk) begin
    if (rst)        raw_q <= 1'b0;
    else if (match) raw_q <= 1'b1;
    else if (clr)   raw_q <= 1'b0;
  end

  assign cmp = cmp_q;
  assign raw = raw_q;

  assert_match_sets_R5: assert property (@(posedge clk) disable iff (rst)
    match |=> raw_q);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !match) |=> !raw_q);

  assert_rearm_step_R8: assert property (@(posedge clk) disable iff (rst)
    (match && rearm && !wr_lo && !wr_hi) |=>
      (cmp_q == $past(cmp_q) + CW'($past(step))));

  assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!(match && rearm) && !wr_lo && !wr_hi) |=> $stable(cmp_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import ct_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] addr,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BUS_W-1:0] step_q;
  logic [CNT_W-1:0] cmp_w;
  logic             raw_w;
  logic             tick;

  logic hit_cnt_lo, hit_cnt_hi, hit_ctrl, hit_stat, hit_cmp_lo, hit_cmp_hi, hit_step;

  assign hit_cnt_lo = (addr == OFS_CNT_LO);
  assign hit_cnt_hi = (addr == OFS_CNT_HI);
  assign hit_ctrl   = (addr == OFS_CTRL);
  assign hit_stat   = (addr == OFS_STAT);
  assign hit_cmp_lo = (addr == OFS_CMP_LO);
  assign hit_cmp_hi = (addr == OFS_CMP_HI);
  assign hit_step   = (addr == OFS_STEP);

  ct_prescaler #(.W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (ctl_q.run),
    .div  (ctl_q.div),
    .tick (tick)
  );

  ct_compare #(.CW(CNT_W), .SW(BUS_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .cmp_en (ctl_q.cmp_en),
    .rearm  (ctl_q.rearm),
    .count  (cnt_q),
    .wr_lo  (wr_en && hit_cmp_lo),
    .wr_hi  (wr_en && hit_cmp_hi),
    .wdata  (wr_data),
    .step   (step_q),
    .clr    (wr_en && hit_stat && wr_data[0]),
    .cmp    (cmp_w),
    .raw    (raw_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en && hit_ctrl) begin
      ctl_q      <= ctl_t'(wr_data[CTL_W-1:0]);
      ctl_q.rsvd <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     step_q <= '0;
    else if (wr_en && hit_step)  step_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (wr_en && hit_cnt_lo)   cnt_q[BUS_W-1:0]     <= wr_data;
    else if (wr_en && hit_cnt_hi)   cnt_q[CNT_W-1:BUS_W] <= wr_data;
    else if (tick)                  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (1'b1)
        hit_cnt_lo: rd_data = cnt_q[BUS_W-1:0];
        hit_cnt_hi: rd_data = cnt_q[CNT_W-1:BUS_W];
        hit_ctrl:   rd_data = BUS_W'(ctl_q);
        hit_stat:   rd_data = BUS_W'(raw_w);
        hit_cmp_lo: rd_data = cmp_w[BUS_W-1:0];
        hit_cmp_hi: rd_data = cmp_w[CNT_W-1:BUS_W];
        hit_step:   rd_data = step_q;
        default:    rd_data = '0;
      endcase
    end
  end

  assign irq = ctl_q.irq_en && raw_w;

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.run && !(wr_en && (hit_cnt_lo || hit_cnt_hi))) |=> $stable(cnt_q));

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit_ctrl) |-> (rd_data[7:4] == 4'h0 && rd_data[BUS_W-1:CTL_W] == '0));

  assert_undecoded_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= 32'h1C) |-> (rd_data == '0));
endmodule

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference model
  longint unsigned m_cnt, m_cmp;
  int unsigned     m_step, m_ctrl, m_pc;
  bit              m_raw;

  function automatic logic [31:0] m_read(logic [31:0] a, logic re);
    if (!re) return 32'h0;
    case (a)
      32'h00: return m_cnt[31:0];
      32'h04: return m_cnt[63:32];
      32'h08: return m_ctrl;
      32'h0C: return {31'h0, m_raw};
      32'h10: return m_cmp[31:0];
      32'h14: return m_cmp[63:32];
      32'h18: return m_step;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_ctrl = 0; m_pc = 0; m_raw = 0;
    end else begin
      bit run, tk, hit;
      int unsigned dv;
      longint unsigned n_cnt, n_cmp;
      run = m_ctrl[0];
      dv  = (m_ctrl >> 8) & 255;
      tk  = run && (m_pc >= dv);
      hit = m_ctrl[1] && (m_cnt >= m_cmp);
      n_cnt = m_cnt;
      if (wr_en && addr == 32'h00)      n_cnt = {m_cnt[63:32], wr_data};
      else if (wr_en && addr == 32'h04) n_cnt = {wr_data, m_cnt[31:0]};
      else if (tk)                      n_cnt = m_cnt + 1;
      n_cmp = m_cmp;
      if (wr_en && addr == 32'h10)      n_cmp = {m_cmp[63:32], wr_data};
      else if (wr_en && addr == 32'h14) n_cmp = {wr_data, m_cmp[31:0]};
      else if (hit && m_ctrl[3])        n_cmp = m_cmp + longint'(m_step);
      if (hit) m_raw = 1;
      else if (wr_en && addr == 32'h0C && wr_data[0]) m_raw = 0;
      m_pc  = (!run || tk) ? 0 : m_pc + 1;
      if (wr_en && addr == 32'h08) m_ctrl = wr_data & 32'h0000_FF0F;
      if (wr_en && addr == 32'h18) m_step = wr_data;
      m_cnt = n_cnt;
      m_cmp = n_cmp;
    end
  end

  // Per-clock comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (!rst) begin
      checks++;
      if (irq !== (m_ctrl[2] && m_raw)) begin
        errors++;
        $display("FAIL %s/R6 irq actual=%0b expected=%0b t=%0t", cur_req, irq, m_ctrl[2] && m_raw, $time);
      end
      checks++;
      if (rd_data !== m_read(addr, rd_en)) begin
        errors++;
        $display("FAIL %s rd_data@%h actual=%h expected=%h t=%0t", cur_req, addr, rd_data, m_read(addr, rd_en), $time);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    addr = a; rd_en = 1'b1;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read@%h actual=%h expected=%h", req, a, rd_data, exp);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    irq_chk(1'b0, "R1");
    for (int i = 0; i < 7; i++) rd_chk(32'(i * 4), 32'h0, "R1");

    // R4: reserved control bits
    cur_req = "R4";
    wr(32'h08, 32'hFFFF_03F0);
    rd_chk(32'h08, 32'h0000_0300, "R4");

    // R2: divide by 4, then hold
    cur_req = "R2";
    wr(32'h08, 32'h0000_0301);
    repeat (40) @(negedge clk);
    rd_chk(32'h00, 32'd10, "R2");
    wr(32'h08, 32'h0000_0300);
    repeat (10) @(negedge clk);
    rd_chk(32'h00, 32'd10, "R2");

    // R3: counter halves
    cur_req = "R3";
    wr(32'h00, 32'hFFFF_FFFE);
    wr(32'h04, 32'h0000_0001);
    rd_chk(32'h00, 32'hFFFF_FFFE, "R3");
    rd_chk(32'h04, 32'h0000_0001, "R3");

    // R5: match while counting
    cur_req = "R5";
    wr(32'h10, 32'h0000_0005);
    wr(32'h14, 32'h0000_0002);
    wr(32'h08, 32'h0000_0002);
    repeat (3) @(negedge clk);
    rd_chk(32'h0C, 32'h0, "R5");
    wr(32'h08, 32'h0000_0003);
    repeat (20) @(negedge clk);
    rd_chk(32'h0C, 32'h1, "R5");
    irq_chk(1'b0, "R6");

    // R7: write-one clear
    cur_req = "R7";
    wr(32'h08, 32'h0000_0001);
    wr(32'h0C, 32'h0);
    rd_chk(32'h0C, 32'h1, "R7");
    wr(32'h0C, 32'h1);
    rd_chk(32'h0C, 32'h0, "R7");
    cur_req = "R5";
    repeat (5) @(negedge clk);
    rd_chk(32'h0C, 32'h0, "R5");

    // R6: interrupt gating
    cur_req = "R6";
    wr(32'h08, 32'h0000_0006);
    repeat (2) @(negedge clk);
    irq_chk(1'b1, "R6");
    wr(32'h08, 32'h0000_0002);
    irq_chk(1'b0, "R6");
    rd_chk(32'h0C, 32'h1, "R6");

    // R8: auto-rearm, single step and carry
    cur_req = "R8";
    wr(32'h08, 32'h0);
    wr(32'h0C, 32'h1);
    wr(32'h00, 32'h100);
    wr(32'h04, 32'h0);
    wr(32'h14, 32'h0);
    wr(32'h10, 32'hF0);
    wr(32'h18, 32'h40);
    wr(32'h08, 32'h0000_000A);
    repeat (3) @(negedge clk);
    rd_chk(32'h10, 32'h130, "R8");
    rd_chk(32'h14, 32'h0, "R8");
    wr(32'h08, 32'h0);
    wr(32'h00, 32'h0);
    wr(32'h04, 32'h1);
    wr(32'h14, 32'h0);
    wr(32'h10, 32'hFFFF_FFF0);
    wr(32'h18, 32'h20);
    wr(32'h08, 32'h0000_000A);
    repeat (3) @(negedge clk);
    rd_chk(32'h10, 32'h10, "R8");
    rd_chk(32'h14, 32'h1, "R8");

    // R9: undecoded and idle reads
    cur_req = "R9";
    rd_chk(32'h1C, 32'h0, "R9");
    rd_chk(32'h40, 32'h0, "R9");
    rd_chk(32'h0A, 32'h0, "R9");
    addr = 32'h04; rd_en = 1'b0; #1;
    checks++;
    if (rd_data !== 32'h0) begin
      errors++;
      $display("FAIL R9 idle read actual=%h expected=%h", rd_data, 32'h0);
    end
    @(negedge clk);

    // R8/R3: periodic run checked by the model every clock
    cur_req = "R8";
    wr(32'h08, 32'h0);
    wr(32'h18, 32'h5);
    wr(32'h00, 32'h0);
    wr(32'h04, 32'h0);
    wr(32'h14, 32'h0);
    wr(32'h10, 32'h3);
    wr(32'h08, 32'h0000_010F);
    for (int n = 0; n < 240; n++) begin
      if (n % 17 == 0)       wr(32'h0C, 32'h1);
      else if (n == 100)     begin cur_req = "R3"; wr(32'h00, 32'h50); end
      else begin addr = (n % 3 == 0) ? 32'h10 : 32'h00; rd_en = 1'b1; @(negedge clk); end
    end
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule